// File: doc/BRIEF.md
# Sensor Register Bus Slave (two-wire, autoincrementing)

This block is the two-wire serial slave that sits in front of the register file of a small sensor converter. It oversamples the clock and data lines with a fast system clock and recognises start, repeated start and stop conditions. It answers to one fixed 7-bit device address and turns bus transfers into single-cycle strobes on a register read/write port. The data line is driven through an open-drain enable only, so the output pulls the line low and never drives it high.

A write transfer loads an 8-bit register pointer and then stores each following byte at the pointer, incrementing the pointer every time. A read transfer streams bytes from the pointer onward, and the pointer advances only when the master acknowledges a byte. A stop condition always parks the pointer at register 0, so a status register can be polled with bare read transfers. Two commands ask the register file to reload its defaults: one pointer value reserved as a reset command, and a reset byte sent after the general-call address. After either command the slave refuses to acknowledge anything for a programmable number of system clock cycles.

Top module: `sensor_i2c_slave`

## Requirements
- R1: After reset the slave releases the data line (`sdaOe` = 0) and asserts neither `regWrEn` nor `cfgReload`.
- R2: An address byte, received MSB first, whose upper seven bits equal `DEV_ADDR` (default 0x48, so the bytes are 0x90 for write and 0x91 for read, with R/W in bit 0 and 1 meaning read) is acknowledged by pulling the data line low in the ninth clock. Any other address except the general call gets no acknowledge. `sdaOe` changes only while SCL is low.
- R3: In a write transfer the first data byte is loaded into the pointer. Each later byte is acknowledged, presented on `regWrData` with `regAddr` equal to the pointer during a one-cycle `regWrEn` pulse, and the pointer then increments.
- R4: In a read transfer each byte is the `regRdData` value for `regAddr` = pointer, sent MSB first. A master acknowledge (data low in the ninth clock) increments the pointer and starts the next byte. A master no-acknowledge returns the slave to idle and leaves the pointer unchanged.
- R5: A repeated start is handled like a start and keeps the pointer value.
- R6: A stop condition returns the slave to idle and clears the pointer to 0x00.
- R7: A data byte written while the pointer is at or above `REG_COUNT` is acknowledged, but no `regWrEn` is issued. The pointer still increments. Reads at such pointers return whatever the register port supplies.
- R8: A pointer byte equal to `RESET_PTR` (default 0xBF) is acknowledged and produces a one-cycle `cfgReload` pulse.
- R9: The general-call address byte 0x00 is acknowledged. A following byte equal to `GC_RESET` (default 0x06) is acknowledged and produces a `cfgReload` pulse. Any other byte after the general call is not acknowledged and causes no reload.
- R10: For `BUSY_CYCLES` system clock cycles after a reload command, no address byte is acknowledged. Once the window has ended, the device address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable: 1 pulls the data line low |
| regAddr | output | 8 | Register pointer presented to the register file |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to store at `regAddr` |
| regRdData | input | 8 | Register file read data for `regAddr` (combinational) |
| cfgReload | output | 1 | One-cycle request to reload all register defaults |

## Verification
The bench builds the slave with `REG_COUNT` = 16 and `BUSY_CYCLES` = 2000, and keeps the default device address and command bytes. The small register count makes a write that runs off the end of the valid range reachable with a two-byte burst from pointer 0x0F. The short blackout, which is still longer than one address byte at the bench's bus rate, lets one run observe both the refused address just after a reload and the acknowledged address once the window has closed.

// File: rtl/sensor_i2c_pkg.sv
package sensor_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  // Bus events decoded by the datapath from the synchronised lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaBit;
  } busEv_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // shift sampled data bit into receive register
    logic ptrLoad;    // load pointer from received byte
    logic ptrInc;     // advance pointer
    logic ptrClear;   // park pointer at 0
    logic txLoad;     // capture read data and drive its MSB
    logic txShift;    // drive next transmit bit
    logic oeAck;      // pull line low for acknowledge
    logic oeRelease;  // let the line float
    logic wrStrobe;   // store received byte at pointer
    logic resetCmd;   // reload request, starts blackout
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WRITE, ST_GCALL, ST_ACK, ST_READ, ST_RDACK, ST_RDNEXT
  } ctrlState_t;

endpackage

// File: rtl/sensor_i2c_dp.sv
module sensor_i2c_dp
  import sensor_i2c_pkg::*;
#(
  parameter int REG_COUNT   = 27,
  parameter int BUSY_CYCLES = 30000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrb_t         strb,
  input  logic [BYTE_W-1:0] regRdData,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              busy,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              cfgReload
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [1:0] sclQ, sdaQ;
  logic sclD, sdaD;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-2:0] txReg;
  logic [BUSY_W-1:0] busyCnt;

  wire sclS = sclQ[1];
  wire sdaS = sdaQ[1];

  // Two-flop synchronisers plus one delayed copy for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 2'b11;
      sdaQ <= 2'b11;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[0], sclIn};
      sdaQ <= {sdaQ[0], sdaIn};
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise = sclS & ~sclD;
    ev.sclFall = ~sclS & sclD;
    ev.startEv = sclS & sclD & sdaD & ~sdaS;
    ev.stopEv  = sclS & sclD & ~sdaD & sdaS;
    ev.sdaBit  = sdaS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte    <= '0;
      ptr       <= '0;
      txReg     <= '0;
      sdaOe     <= 1'b0;
      busyCnt   <= '0;
      cfgReload <= 1'b0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaS};

      if (strb.ptrClear || strb.resetCmd) ptr <= '0;
      else if (strb.ptrLoad)              ptr <= rxByte;
      else if (strb.ptrInc)               ptr <= ptr + 1'b1;

      if (strb.txLoad) begin
        txReg <= regRdData[BYTE_W-2:0];
        sdaOe <= ~regRdData[BYTE_W-1];
      end else if (strb.txShift) begin
        txReg <= {txReg[BYTE_W-3:0], 1'b0};
        sdaOe <= ~txReg[BYTE_W-2];
      end else if (strb.oeAck) begin
        sdaOe <= 1'b1;
      end else if (strb.oeRelease) begin
        sdaOe <= 1'b0;
      end

      if (strb.resetCmd)      busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;

      cfgReload <= strb.resetCmd;
    end
  end

  assign busy      = (busyCnt != '0);
  assign regAddr   = ptr;
  assign regWrData = rxByte;
  assign regWrEn   = strb.wrStrobe && ({1'b0, ptr} < (BYTE_W + 1)'(REG_COUNT));

  // The open-drain enable must never move while SCL is high
  p_oe_stable_scl_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD) |-> $stable(sdaOe));

  // A stop leaves the pointer at register 0
  p_ptr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopEv |=> (ptr == '0));

  // Reload request is a single-cycle pulse
  p_reload_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgReload |=> !cfgReload);

endmodule

// File: rtl/sensor_i2c_ctrl.sv
module sensor_i2c_ctrl
  import sensor_i2c_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR  = 7'h48,
  parameter logic [BYTE_W-1:0] RESET_PTR = 8'hBF,
  parameter logic [BYTE_W-1:0] GC_RESET  = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              busy,
  output ctrlStrb_t         strb
);

  ctrlState_t state, stateN, ackNext, ackNextN;
  logic [BIT_CNT_W-1:0] bitCnt, bitCntN;
  logic byteFull, byteFullN, ptrPhase, ptrPhaseN;

  always_comb begin
    strb      = '0;
    stateN    = state;
    ackNextN  = ackNext;
    bitCntN   = bitCnt;
    byteFullN = byteFull;
    ptrPhaseN = ptrPhase;
    if (ev.stopEv) begin
      strb.ptrClear  = 1'b1;
      strb.oeRelease = 1'b1;
      stateN         = ST_IDLE;
    end else if (ev.startEv) begin
      strb.oeRelease = 1'b1;
      stateN         = ST_ADDR;
      bitCntN        = '0;
      byteFullN      = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WRITE, ST_GCALL: begin
          if (ev.sclRise && !byteFull) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 1'b1;
            if (bitCnt == '1) byteFullN = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            byteFullN = 1'b0;
            bitCntN   = '0;
            stateN    = ST_IDLE;
            if (state == ST_ADDR) begin
              if (!busy && rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                strb.oeAck = 1'b1;
                ptrPhaseN  = 1'b1;
                ackNextN   = rxByte[0] ? ST_READ : ST_WRITE;
                stateN     = ST_ACK;
              end else if (!busy && rxByte == '0) begin
                strb.oeAck = 1'b1;
                ackNextN   = ST_GCALL;
                stateN     = ST_ACK;
              end
            end else if (state == ST_WRITE) begin
              strb.oeAck = 1'b1;
              stateN     = ST_ACK;
              ackNextN   = ST_WRITE;
              if (ptrPhase) begin
                strb.ptrLoad = 1'b1;
                ptrPhaseN    = 1'b0;
                if (rxByte == RESET_PTR) begin
                  strb.resetCmd = 1'b1;
                  ackNextN      = ST_IDLE;
                end
              end else begin
                strb.wrStrobe = 1'b1;
                strb.ptrInc   = 1'b1;
              end
            end else if (rxByte == GC_RESET) begin
              strb.oeAck    = 1'b1;
              strb.resetCmd = 1'b1;
              ackNextN      = ST_IDLE;
              stateN        = ST_ACK;
            end
          end
        end
        ST_ACK: if (ev.sclFall) begin
          bitCntN = '0;
          stateN  = ackNext;
          if (ackNext == ST_READ) strb.txLoad    = 1'b1;
          else                    strb.oeRelease = 1'b1;
        end
        ST_READ: if (ev.sclFall) begin
          if (bitCnt == '1) begin
            strb.oeRelease = 1'b1;
            stateN         = ST_RDACK;
          end else begin
            strb.txShift = 1'b1;
            bitCntN      = bitCnt + 1'b1;
          end
        end
        ST_RDACK: if (ev.sclRise) begin
          if (!ev.sdaBit) begin
            strb.ptrInc = 1'b1;
            stateN      = ST_RDNEXT;
          end else begin
            stateN = ST_IDLE;
          end
        end
        ST_RDNEXT: if (ev.sclFall) begin
          strb.txLoad = 1'b1;
          bitCntN     = '0;
          stateN      = ST_READ;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackNext  <= ST_IDLE;
      bitCnt   <= '0;
      byteFull <= 1'b0;
      ptrPhase <= 1'b0;
    end else begin
      state    <= stateN;
      ackNext  <= ackNextN;
      bitCnt   <= bitCntN;
      byteFull <= byteFullN;
      ptrPhase <= ptrPhaseN;
    end
  end

  // No address acknowledge while the reload blackout runs
  p_ack_not_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && strb.oeAck) |-> !busy);

  // Read phases never store into the register file
  p_rd_no_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_READ, ST_RDACK, ST_RDNEXT}) |-> !strb.wrStrobe);

endmodule

// File: rtl/sensor_i2c_slave.sv
module sensor_i2c_slave
  import sensor_i2c_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h48,
  parameter int                REG_COUNT   = 27,
  parameter int                BUSY_CYCLES = 30000,
  parameter logic [BYTE_W-1:0] RESET_PTR   = 8'hBF,
  parameter logic [BYTE_W-1:0] GC_RESET    = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              cfgReload
);

  busEv_t            ev;
  ctrlStrb_t         strb;
  logic [BYTE_W-1:0] rxByte;
  logic              busy;

  sensor_i2c_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .RESET_PTR(RESET_PTR),
    .GC_RESET (GC_RESET)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .ev    (ev),
    .rxByte(rxByte),
    .busy  (busy),
    .strb  (strb)
  );

  sensor_i2c_dp #(
    .REG_COUNT  (REG_COUNT),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .regRdData(regRdData),
    .ev       (ev),
    .rxByte   (rxByte),
    .busy     (busy),
    .sdaOe    (sdaOe),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .cfgReload(cfgReload)
  );

endmodule

// File: tb/sensor_i2c_slave_tb.sv
module sensor_i2c_slave_tb_top;

  localparam int Q      = 20;
  localparam int NREG   = 16;
  localparam int BUSY_C = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, regWrEn, cfgReload;
  logic [7:0] regAddr, regWrData, regRdData;
  wire  sdaBus = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  sensor_i2c_slave #(.REG_COUNT(NREG), .BUSY_CYCLES(BUSY_C)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cfgReload(cfgReload)
  );

  // Register file model
  function automatic logic [7:0] defVal(int a);
    return 8'((a * 7) + 8'h11);
  endfunction

  logic [7:0] mem [256];
  int wrCount = 0, badWr = 0, reloadCount = 0;
  assign regRdData = mem[regAddr];

  initial for (int i = 0; i < 256; i++) mem[i] = defVal(i);

  always @(posedge clk) begin
    if (cfgReload) begin
      reloadCount++;
      for (int i = 0; i < 256; i++) mem[i] <= defVal(i);
    end else if (regWrEn) begin
      wrCount++;
      if (regAddr >= NREG) badWr++;
      mem[regAddr] <= regWrData;
    end
  end

  // Scoreboard
  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t expQ[$];
  item_t obsQ[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (obsQ.size() > 0 && expQ.size() > 0) begin
      item_t o, e;
      o = obsQ.pop_front();
      e = expQ.pop_front();
      check(e.tag, o.val, e.val);
    end
  end

  // Master bus tasks
  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mStart();
    sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(Q);
    sdaM = 1'b0; wt(Q); sclM = 1'b0; wt(Q);
  endtask

  task automatic mStop();
    sdaM = 1'b0; wt(Q); sclM = 1'b1; wt(Q); sdaM = 1'b1; wt(Q);
  endtask

  task automatic mBit(logic b);
    sdaM = b; wt(Q); sclM = 1'b1; wt(2 * Q); sclM = 1'b0; wt(Q);
  endtask

  task automatic mRdBit(output logic b);
    sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(Q); b = sdaBus;
    wt(Q); sclM = 1'b0; wt(Q);
  endtask

  // expAck: 0 = slave acknowledges, 1 = no acknowledge
  task automatic sendByte(logic [7:0] v, logic expAck, string tag);
    logic a;
    for (int i = 7; i >= 0; i--) mBit(v[i]);
    mRdBit(a);
    expQ.push_back('{tag, {7'd0, expAck}});
    obsQ.push_back('{tag, {7'd0, a}});
  endtask

  task automatic recvByte(logic [7:0] expV, logic mAck, string tag);
    logic [7:0] got;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      mRdBit(b);
      got[i] = b;
    end
    mBit(!mAck);
    expQ.push_back('{tag, expV});
    obsQ.push_back('{tag, got});
  endtask

  initial begin
    int w0, r0;
    wt(10);
    rstN = 1'b1;
    wt(2);
    check("R1 sdaOe after reset", {7'd0, sdaOe}, 8'd0);
    check("R1 regWrEn after reset", {7'd0, regWrEn}, 8'd0);
    check("R1 cfgReload after reset", {7'd0, cfgReload}, 8'd0);
    wt(20);

    // R3: pointer then two data bytes
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'h03, 0, "R3 pointer ack");
    sendByte(8'hA1, 0, "R3 data ack 1");
    sendByte(8'hB2, 0, "R3 data ack 2");
    mStop();
    check("R3 write strobes", 8'(wrCount), 8'd2);

    // R6: after stop a bare read starts at register 0
    mStart();
    sendByte(8'h91, 0, "R2 read address ack");
    recvByte(defVal(0), 1, "R6 read reg0 after stop");
    recvByte(defVal(1), 0, "R4 read reg1 autoincrement");
    mStop();

    // R5: pointer kept across repeated start, R4 read increments on ack
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'h03, 0, "R3 pointer ack");
    mStart();
    sendByte(8'h91, 0, "R5 read after repeated start ack");
    recvByte(8'hA1, 1, "R5 reg3 via repeated start");
    recvByte(8'hB2, 1, "R3 reg4 stored value");
    recvByte(defVal(5), 0, "R4 reg5 streamed");
    mStop();

    // R4: master nack leaves pointer unchanged
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'h07, 0, "R3 pointer ack");
    mStart();
    sendByte(8'h91, 0, "R2 read address ack");
    recvByte(defVal(7), 0, "R4 reg7 nack");
    mStart();
    sendByte(8'h91, 0, "R2 read address ack");
    recvByte(defVal(7), 0, "R4 reg7 again no increment");
    mStop();

    // R2: foreign address not acknowledged
    mStart();
    sendByte(8'hA0, 1, "R2 foreign address nack");
    mStop();

    // R7: write past the end is acked but discarded
    w0 = wrCount;
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'h0F, 0, "R3 pointer ack");
    sendByte(8'h11, 0, "R7 last valid data ack");
    sendByte(8'h22, 0, "R7 invalid address data ack");
    mStop();
    check("R7 one valid strobe", 8'(wrCount - w0), 8'd1);
    check("R7 no strobe out of range", 8'(badWr), 8'd0);
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'h0F, 0, "R3 pointer ack");
    mStart();
    sendByte(8'h91, 0, "R2 read address ack");
    recvByte(8'h11, 1, "R7 reg15 stored");
    recvByte(defVal(16), 0, "R7 reg16 unchanged past end");
    mStop();

    // R8/R10: reset pointer command and blackout
    r0 = reloadCount;
    mStart();
    sendByte(8'h90, 0, "R2 write address ack");
    sendByte(8'hBF, 0, "R8 reset pointer ack");
    mStop();
    check("R8 reload pulse", 8'(reloadCount - r0), 8'd1);
    mStart();
    sendByte(8'h90, 1, "R10 nack during blackout");
    mStop();
    wt(BUSY_C + 200);
    mStart();
    sendByte(8'h90, 0, "R10 ack after blackout");
    sendByte(8'h03, 0, "R3 pointer ack");
    mStart();
    sendByte(8'h91, 0, "R2 read address ack");
    recvByte(defVal(3), 0, "R8 reg3 back to default");
    mStop();

    // R9: general call
    r0 = reloadCount;
    mStart();
    sendByte(8'h00, 0, "R9 general call ack");
    sendByte(8'h05, 1, "R9 other byte nack");
    mStop();
    check("R9 no reload on other byte", 8'(reloadCount - r0), 8'd0);
    mStart();
    sendByte(8'h00, 0, "R9 general call ack");
    sendByte(8'h06, 0, "R9 reset byte ack");
    mStop();
    check("R9 reload on reset byte", 8'(reloadCount - r0), 8'd1);
    mStart();
    sendByte(8'h91, 1, "R10 nack after general call reset");
    mStop();
    check("R1 line released at end", {7'd0, sdaOe}, 8'd0);

    wt(20);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
        wt(5);
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog act=hung exp=finished");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule